// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a watchdog timer that runs on its own oscillator clock. While enabled, it counts toward a timeout chosen by a 3-bit prescale select. When the count expires, it emits a one-cycle system reset request, restarts the count and stays enabled. Software keeps the system alive by pulsing a kick input, which restarts the count.

Software programs the block through a single-cycle write port. Each write carries an enable bit, a change-enable bit and the prescale select. Turning the watchdog on takes one write. Turning it off takes a guarded two-step sequence. The first write sets the change-enable and enable bits together, which opens a short unlock window. A second write that clears the enable bit must land inside that window.

A static safety-level input can lock the watchdog on. At the locking level, the disable sequence has no effect.

Top module: `wdg_protected`

## Requirements
- R1: One cycle after a synchronous reset, the outputs are: `en_o` = 1 only if `safety_lvl_i` equals 2'b10, otherwise 0; `chg_o` = 0; `psel_o` = 3'b000; `wdt_rst_o` = 0.
- R2: A write with `wr_en_i` = 1 sets `en_o` to 1 on the next cycle, whatever the current state.
- R3: A write with both `wr_chg_i` and `wr_en_i` at 1 raises `chg_o` on the next cycle. `chg_o` then stays high for exactly 4 cycles and clears by itself. A write with `wr_chg_i` = 1 and `wr_en_i` = 0 does not raise `chg_o`.
- R4: A write with `wr_en_i` = 0, made while `chg_o` is 1, clears `en_o` and `chg_o` on the next cycle. This holds when the write is issued 1 to 4 cycles after the opening write.
- R5: A write with `wr_en_i` = 0 while `chg_o` is 0 leaves `en_o` unchanged. This includes a write issued 5 cycles after the opening write, once the window has expired.
- R6: While `safety_lvl_i` is 2'b10, `en_o` stays 1, even when the full disable sequence is performed.
- R7: While enabled, `wdt_rst_o` pulses high for exactly one cycle every `UNIT_CYC << psel_o` cycles, and `en_o` stays 1 after the pulse.
- R8: A kick pulse restarts the count. The next reset pulse appears exactly `UNIT_CYC << psel_o` cycles after the cycle in which the kick was sampled.
- R9: A write that changes `psel_o` restarts the count with the new limit. The first pulse follows that write by exactly the new timeout.
- R10: While `en_o` is 0, `wdt_rst_o` stays 0 and the count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog oscillator clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| safety_lvl_i | input | 2 | Static safety level; 2'b10 locks the watchdog on |
| wr_i | input | 1 | Control write strobe, one cycle per write |
| wr_en_i | input | 1 | Enable bit value carried by the write |
| wr_chg_i | input | 1 | Change-enable bit value carried by the write |
| wr_psel_i | input | 3 | Prescale select carried by the write |
| kick_i | input | 1 | Restarts the timeout count |
| en_o | output | 1 | Current enable bit |
| chg_o | output | 1 | Unlock window open |
| psel_o | output | 3 | Current prescale select |
| wdt_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that `safety_lvl_i` changes only while reset is held. The lock property therefore checks only cycles in which the level was also at the locking value one cycle earlier. The window-length check counts consecutive high cycles of `chg_o`, and restarts that count whenever a new opening write arrives.

The bench keeps to these assumptions. It changes the safety level only under reset, and it never reopens a window that is still open. It runs all eight prescale codes with a small unit length. It also runs the second write of the disable sequence at every offset from 1 to 5 cycles after the opening write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned PSEL_W  = 3;
   localparam int unsigned NUM_SEL = 1 << PSEL_W;
   localparam int unsigned LVL_W   = 2;

   typedef struct packed {
      logic              en;
      logic              chg;
      logic [PSEL_W-1:0] psel;
   } wdg_ctrl_t;

   typedef struct packed {
      logic              en;
      logic              chg;
      logic [PSEL_W-1:0] psel;
   } wdg_wr_t;
endpackage

// File: rtl/wdg_unlock_win.sv
module wdg_unlock_win #(
   parameter int unsigned WIN_CYC = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic open_i,
   input  logic consume_i,
   output logic active_o
);
   localparam int unsigned WC_W = $clog2(WIN_CYC + 1);
   localparam logic [WC_W-1:0] WIN_LOAD = WC_W'(WIN_CYC);

   generate
      if (WIN_CYC < 1) begin : g_bad_win
         $error("wdg_unlock_win: WIN_CYC must be at least 1");
      end
   endgenerate

   logic [WC_W-1:0] left_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         left_q <= '0;
      end else if (open_i) begin
         left_q <= WIN_LOAD;
      end else if (consume_i) begin
         left_q <= '0;
      end else if (left_q != '0) begin
         left_q <= left_q - WC_W'(1);
      end
   end

   assign active_o = (left_q != '0);
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
   import wdg_pkg::*;
#(
   parameter int unsigned WIN_CYC    = 4,
   parameter int unsigned LOCK_LEVEL = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [LVL_W-1:0]  safety_lvl_i,
   input  logic              wr_i,
   input  wdg_wr_t           wr_data_i,
   output wdg_ctrl_t         ctrl_o,
   output logic              psel_upd_o
);
   generate
      if (LOCK_LEVEL >= (1 << LVL_W)) begin : g_bad_lvl
         $error("wdg_ctrl_reg: LOCK_LEVEL does not fit the safety level input");
      end
   endgenerate

   logic locked;
   logic open_win;
   logic consume_win;
   logic win_active;
   logic en_q;
   logic [PSEL_W-1:0] psel_q;
   logic en_d;

   assign locked      = (safety_lvl_i == LVL_W'(LOCK_LEVEL));
   assign open_win    = wr_i && wr_data_i.chg && wr_data_i.en;
   assign consume_win = wr_i && !wr_data_i.en && win_active;

   wdg_unlock_win #(
      .WIN_CYC (WIN_CYC)
   ) win_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .open_i    (open_win),
      .consume_i (consume_win),
      .active_o  (win_active)
   );

   always_comb begin
      en_d = en_q;
      if (wr_i) begin
         if (wr_data_i.en) begin
            en_d = 1'b1;
         end else if (win_active) begin
            en_d = 1'b0;
         end
      end
      if (locked) begin
         en_d = 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q   <= locked;
         psel_q <= '0;
      end else begin
         en_q <= en_d;
         if (wr_i) begin
            psel_q <= wr_data_i.psel;
         end
      end
   end

   assign psel_upd_o  = wr_i && (wr_data_i.psel != psel_q);
   assign ctrl_o.en   = en_q;
   assign ctrl_o.chg  = win_active;
   assign ctrl_o.psel = psel_q;
endmodule

// File: rtl/wdg_limit.sv
module wdg_limit
   import wdg_pkg::*;
#(
   parameter int unsigned UNIT_CYC = 16384,
   parameter int unsigned LIM_W    = 22,
   parameter int unsigned VARIANT  = 0
) (
   input  logic [PSEL_W-1:0] psel_i,
   output logic [LIM_W-1:0]  limit_o
);
   localparam logic [LIM_W-1:0] UNIT_V = LIM_W'(UNIT_CYC);

   generate
      if (VARIANT == 0) begin : g_shift
         assign limit_o = UNIT_V << psel_i;
      end else if (VARIANT == 1) begin : g_table
         logic [LIM_W-1:0] tab [NUM_SEL];
         for (genvar g = 0; g < NUM_SEL; g++) begin : g_ent
            assign tab[g] = UNIT_V << g;
         end
         assign limit_o = tab[psel_i];
      end else begin : g_bad_variant
         $error("wdg_limit: VARIANT must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned LIM_W = 22
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic [LIM_W-1:0] limit_i,
   output logic             expire_o
);
   logic [LIM_W-1:0] cnt_q;
   logic             hit;

   assign hit = (cnt_q == (limit_i - LIM_W'(1)));

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !en_i) begin
         cnt_q    <= '0;
         expire_o <= 1'b0;
      end else if (restart_i) begin
         cnt_q    <= '0;
         expire_o <= 1'b0;
      end else if (hit) begin
         cnt_q    <= '0;
         expire_o <= 1'b1;
      end else begin
         cnt_q    <= cnt_q + LIM_W'(1);
         expire_o <= 1'b0;
      end
   end
endmodule

// File: rtl/wdg_protected.sv
module wdg_protected
   import wdg_pkg::*;
#(
   parameter int unsigned UNIT_CYC      = 16384,
   parameter int unsigned WIN_CYC       = 4,
   parameter int unsigned LOCK_LEVEL    = 2,
   parameter int unsigned LIMIT_VARIANT = 0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] safety_lvl_i,
   input  logic       wr_i,
   input  logic       wr_en_i,
   input  logic       wr_chg_i,
   input  logic [2:0] wr_psel_i,
   input  logic       kick_i,
   output logic       en_o,
   output logic       chg_o,
   output logic [2:0] psel_o,
   output logic       wdt_rst_o
);
   localparam int unsigned LIM_W = $clog2(UNIT_CYC) + NUM_SEL;

   generate
      if (UNIT_CYC < 2) begin : g_bad_unit
         $error("wdg_protected: UNIT_CYC must be at least 2");
      end
   endgenerate

   wdg_wr_t          wr_data;
   wdg_ctrl_t        ctrl;
   logic             psel_upd;
   logic [LIM_W-1:0] limit;

   assign wr_data.en   = wr_en_i;
   assign wr_data.chg  = wr_chg_i;
   assign wr_data.psel = wr_psel_i;

   wdg_ctrl_reg #(
      .WIN_CYC    (WIN_CYC),
      .LOCK_LEVEL (LOCK_LEVEL)
   ) ctrl_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .safety_lvl_i (safety_lvl_i),
      .wr_i         (wr_i),
      .wr_data_i    (wr_data),
      .ctrl_o       (ctrl),
      .psel_upd_o   (psel_upd)
   );

   wdg_limit #(
      .UNIT_CYC (UNIT_CYC),
      .LIM_W    (LIM_W),
      .VARIANT  (LIMIT_VARIANT)
   ) limit_i (
      .psel_i  (ctrl.psel),
      .limit_o (limit)
   );

   wdg_counter #(
      .LIM_W (LIM_W)
   ) cnt_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (ctrl.en),
      .restart_i (kick_i || psel_upd),
      .limit_i   (limit),
      .expire_o  (wdt_rst_o)
   );

   assign en_o   = ctrl.en;
   assign chg_o  = ctrl.chg;
   assign psel_o = ctrl.psel;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int unsigned WIN_CYC    = 4,
   parameter int unsigned LOCK_LEVEL = 2
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] safety_lvl_i,
   input logic       wr_i,
   input logic       wr_en_i,
   input logic       wr_chg_i,
   input logic       kick_i,
   input logic       en_o,
   input logic       chg_o,
   input logic       wdt_rst_o
);
   logic [7:0] chg_run;
   logic       locked;

   assign locked = (safety_lvl_i == 2'(LOCK_LEVEL));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chg_run <= '0;
      end else if (wr_i && wr_chg_i && wr_en_i) begin
         chg_run <= '0;
      end else if (chg_o) begin
         chg_run <= (chg_run == 8'hff) ? chg_run : chg_run + 8'd1;
      end else begin
         chg_run <= '0;
      end
   end

   AST_LOCK_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked && $past(locked)) |-> en_o); // R6
   AST_WIN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_o |-> (chg_run < 8'(WIN_CYC))); // R3
   AST_WIN_OPEN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chg_o) |-> $past(wr_i && wr_chg_i && wr_en_i)); // R3
   AST_CLEAR_NEEDS_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_o) |-> ($past(chg_o) && !$past(locked))); // R5
   AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdt_rst_o |=> !wdt_rst_o); // R7
   AST_RST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdt_rst_o |-> $past(en_o)); // R10
   AST_KICK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick_i |=> !wdt_rst_o); // R8
endmodule

bind wdg_protected wdg_chk #(
   .WIN_CYC    (WIN_CYC),
   .LOCK_LEVEL (LOCK_LEVEL)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .safety_lvl_i (safety_lvl_i),
   .wr_i         (wr_i),
   .wr_en_i      (wr_en_i),
   .wr_chg_i     (wr_chg_i),
   .kick_i       (kick_i),
   .en_o         (en_o),
   .chg_o        (chg_o),
   .wdt_rst_o    (wdt_rst_o)
);

// File: tb/wdg_protected_tb.sv
`timescale 1ns/1ps
module wdg_protected_tb_top;
   localparam int UNIT = 4;
   localparam int WIN  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] safety = 2'b00;
   logic       wr = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_chg = 1'b0;
   logic [2:0] wr_psel = 3'b000;
   logic       kick = 1'b0;
   logic       en, chg, rst_req;
   logic [2:0] psel;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdg_protected #(
      .UNIT_CYC (UNIT),
      .WIN_CYC  (WIN)
   ) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .safety_lvl_i (safety),
      .wr_i         (wr),
      .wr_en_i      (wr_en),
      .wr_chg_i     (wr_chg),
      .wr_psel_i    (wr_psel),
      .kick_i       (kick),
      .en_o         (en),
      .chg_o        (chg),
      .psel_o       (psel),
      .wdt_rst_o    (rst_req)
   );

   task automatic check(input int act, input int exp, input string tag);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] lvl);
      safety = lvl;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write(input logic e, input logic c, input logic [2:0] p);
      wr = 1'b1; wr_en = e; wr_chg = c; wr_psel = p;
      @(negedge clk);
      wr = 1'b0; wr_en = 1'b0; wr_chg = 1'b0;
   endtask

   task automatic wait_pulse(output int n);
      n = 0;
      while (!rst_req && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic period(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rst_req && n < 5000);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int n;
      int quiet;
      @(negedge clk);
      do_reset(2'b00);
      // R1 reset state, unlocked
      check(en, 0, "R1 en");
      check(chg, 0, "R1 chg");
      check(psel, 0, "R1 psel");
      check(rst_req, 0, "R1 rst");

      // R10 disabled: no pulse
      quiet = 0;
      repeat (40) begin @(negedge clk); if (rst_req) quiet++; end
      check(quiet, 0, "R10 disabled pulses");

      // R2 enable by write
      write(1'b1, 1'b0, 3'd0);
      check(en, 1, "R2 enable");

      // R9 and R7 sweep over every prescale code
      for (int k = 1; k <= 8; k++) begin
         int p;
         p = k % 8;
         write(1'b1, 1'b0, 3'(p));
         wait_pulse(n);
         check(n, UNIT << p, $sformatf("R9 first pulse psel=%0d", p));
         period(n);
         check(n, UNIT << p, $sformatf("R7 period psel=%0d", p));
         @(negedge clk);
         check(rst_req, 0, "R7 single cycle");
         check(en, 1, "R7 stays enabled");
      end

      // R8 kick restarts count
      write(1'b1, 1'b0, 3'd2);
      for (int d = 3; d <= 12; d += 3) begin
         repeat (d) @(negedge clk);
         kick = 1'b1;
         @(negedge clk);
         kick = 1'b0;
         wait_pulse(n);
         check(n, UNIT << 2, $sformatf("R8 kick after %0d", d));
      end

      // R5 clears without window ignored
      write(1'b0, 1'b0, 3'd2);
      check(en, 1, "R5 plain clear ignored");
      write(1'b0, 1'b1, 3'd2);
      check(chg, 0, "R3 no window without en");
      check(en, 1, "R5 chg-only write ignored");
      write(1'b0, 1'b0, 3'd2);
      check(en, 1, "R5 clear after chg-only write");

      // R3 window length
      write(1'b1, 1'b1, 3'd2);
      for (int j = 0; j < 6; j++) begin
         check(chg, (j < WIN) ? 1 : 0, $sformatf("R3 window obs %0d", j));
         @(negedge clk);
      end

      // R4 / R5 second write at every offset
      for (int k = 0; k <= WIN; k++) begin
         write(1'b1, 1'b1, 3'd2);
         repeat (k) @(negedge clk);
         write(1'b0, 1'b0, 3'd2);
         if (k < WIN) begin
            check(en, 0, $sformatf("R4 clear offset %0d", k + 1));
            check(chg, 0, "R4 window consumed");
            quiet = 0;
            repeat (3 * (UNIT << 2)) begin @(negedge clk); if (rst_req) quiet++; end
            check(quiet, 0, "R10 no pulse after disable");
            write(1'b1, 1'b0, 3'd2);
         end else begin
            check(en, 1, "R5 late clear ignored");
         end
      end

      // R6 locked level
      do_reset(2'b10);
      check(en, 1, "R1 locked reset en");
      check(psel, 0, "R1 locked reset psel");
      write(1'b1, 1'b1, 3'd0);
      write(1'b0, 1'b0, 3'd0);
      check(en, 1, "R6 sequence blocked");
      wait_pulse(n);
      period(n);
      check(n, UNIT, "R6 locked still times out");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule